// File: doc/BRIEF.md
# Pulse Counter Status Register Bank

This block sits beside a 32-bit up/down pulse counter fed by a tachometer. It holds a programmable 32-bit compare value and reports two flags against the live count. One flag says the count is below the compare value. The other is a sticky flag that says the count has matched it. It also keeps sticky status for three external inputs: an edge-captured latch input, a count-stop input and an origin/clear input. It records the direction of the most recent count step and a carry event. All of these are read and cleared through a small word-wide register bus.

A second function watches a backplane synchronisation clock. When no edge of that clock arrives for a fixed number of cycles, the block raises a clock-off flag and switches its `sample_tick` output to an internal divider. It switches back once a run of edges has been seen again. Software clears each sticky bit by writing a zero to its own bit of a clear register. That register always reads back ones in its defined bits. A set condition present in the same cycle as a clear wins.

Top module: `pcnt_status_bank`

## Requirements
- R1: The less-than flag (`cmp_less`, status bit 1) is high exactly when the unsigned counter value is below the compare value. It follows the inputs with no clock delay.
- R2: The equal flag (`cmp_equal`, status bit 2) sets on a clock edge where the counter equals the compare value. It then holds until a write to the clear register (address 6) with bit 12 at zero.
- R3: The latch flag (status bit 3) sets only while control bit 0 is 1, on the edge of the latch input selected by control bit 2 (1 = rising, 0 = falling). It holds until a clear-register write with bit 13 at zero.
- R4: The stop flag (status bit 4) sets while the stop input is 1 and control bit 1 is 1. It holds after the input falls, until a clear-register write with bit 14 at zero.
- R5: The origin flag (status bit 5) sets while the origin input is 1. It holds until a clear-register write with bit 15 at zero.
- R6: Status bit 7 takes the direction input (0 forward, 1 reverse) on each cycle with the count-step input high. Without a step it is unchanged.
- R7: The carry flag (status bit 0) sets on a carry pulse and clears on a clear-register write with bit 0 at zero. Address 6 always reads 16'hF001.
- R8: The clock-off flag (`clk_off`, status bit 6) is 1 out of reset. It sets when 16 cycles pass with no synchronised rising edge of the sync clock. It clears after 4 edges in a row, each less than 16 cycles apart.
- R9: `sample_tick` pulses once per synchronised sync-clock rising edge while the clock is present. While `clk_off` is 1 it pulses once every 8 cycles from an internal divider.
- R10: When a set condition and a write-zero clear for the same sticky bit fall in the same cycle, the bit ends up set.
- R11: Every external input passes through a two-flop synchroniser. A level on the origin input shows in status on the third rising clock edge after it is applied, and not earlier.
- R12: Register map: address 0 and 1 read the counter low and high halves. Addresses 2 and 3 read and write the compare low and high halves. Address 4 reads and writes the control bits [2:0]. Address 5 reads status. Address 7 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_value | input | 32 | Current pulse counter value |
| cnt_step | input | 1 | One-cycle pulse for each count |
| cnt_dir | input | 1 | Direction of the count on `cnt_step` (1 = reverse) |
| carry_pulse | input | 1 | One-cycle carry event from the counter |
| latch_in | input | 1 | External latch input, asynchronous |
| stop_in | input | 1 | External count-stop input, asynchronous |
| origin_in | input | 1 | External origin/clear input, asynchronous |
| sync_clk_in | input | 1 | Backplane synchronisation clock, asynchronous |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| cmp_less | output | 1 | Counter below compare value |
| cmp_equal | output | 1 | Sticky counter-equals-compare flag |
| clk_off | output | 1 | Sync clock missing; internal clock in use |
| sample_tick | output | 1 | Sample strobe from the selected clock source |

## Verification
A corrupted sticky register appears at status address 5 on the next read. The two kinds of fault look different: a bit that failed to hold drops one cycle after the set condition goes away, and a clear decoded from the wrong bit position leaves the targeted flag standing while a neighbour drops. A fault in the synchroniser depth moves the origin flag one edge earlier or later than the third edge. A fault in the clock monitor's gap or run counter shows on `clk_off` within a few cycles of the 16-cycle or 4-edge boundary, and it changes the count of `sample_tick` pulses seen in a fixed window.

// File: rtl/pcnt_pkg.sv
// Package: shared register addresses, bit positions and status layout for
// the pulse counter status bank. Assumes a 16-bit register bus.
package pcnt_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_CNT_LO = 3'd0,
        REG_CNT_HI = 3'd1,
        REG_CMP_LO = 3'd2,
        REG_CMP_HI = 3'd3,
        REG_CTRL   = 3'd4,
        REG_STAT   = 3'd5,
        REG_CLR    = 3'd6,
        REG_NONE   = 3'd7
    } reg_addr_e;

    // Sticky flag slots inside the sticky vector
    localparam int SK_CARRY  = 0;
    localparam int SK_EQ     = 1;
    localparam int SK_LATCH  = 2;
    localparam int SK_STOP   = 3;
    localparam int SK_ORIGIN = 4;
    localparam int SK_N      = 5;

    // Control register bits
    localparam int CTL_LATCH_EN = 0;
    localparam int CTL_STOP_EN  = 1;
    localparam int CTL_RISE_SEL = 2;
    localparam int CTL_W        = 3;

    // Clear-register bit that clears each sticky slot
    function automatic int clr_bit(input int slot);
        case (slot)
            SK_CARRY: return 0;
            SK_EQ:    return 12;
            SK_LATCH: return 13;
            SK_STOP:  return 14;
            default:  return 15;
        endcase
    endfunction

    localparam logic [DATA_W-1:0] CLR_READBACK = 16'hF001;

    // Status word, most significant field first (bit 7 down to bit 0)
    typedef struct packed {
        logic dir;
        logic clk_off;
        logic origin;
        logic stop;
        logic latch;
        logic equal;
        logic less;
        logic carry;
    } status_t;

endpackage

// File: rtl/pcnt_sync.sv
// Module: multi-stage synchroniser for a vector of asynchronous inputs.
// Assumes each bit is an independent level; no bus coherency is implied.
module pcnt_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    // Shift each input through STAGES flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= din;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/pcnt_sticky.sv
// Module: vector of sticky flags. Each bit sets on its set input and clears on
// its clear input; set wins when both are high in the same cycle.
module pcnt_sticky #(
    parameter int WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set,
    input  logic [WIDTH-1:0] clr,
    output logic [WIDTH-1:0] q
);
    // Hold, clear, then apply set on top
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= (q & ~clr) | set;
        end
    end
endmodule

// File: rtl/pcnt_clk_mon.sv
// Module: watches a synchronised sync-clock level for rising edges. It flags
// loss after LOSS_LIMIT edge-free cycles and recovery after GOOD_EDGES edges
// in a row. It drives a sample strobe from the edges or from an internal
// divider. Assumes sync_lvl is already synchronised to clk.
module pcnt_clk_mon #(
    parameter int LOSS_LIMIT = 16,
    parameter int GOOD_EDGES = 4,
    parameter int INT_DIV    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_lvl,
    output logic clk_off,
    output logic tick
);
    localparam int GAP_W = $clog2(LOSS_LIMIT + 1);
    localparam int RUN_W = $clog2(GOOD_EDGES + 1);
    localparam int DIV_W = $clog2(INT_DIV);

    logic             prev_q;
    logic [GAP_W-1:0] gap_q;
    logic [RUN_W-1:0] run_q;
    logic [DIV_W-1:0] div_q;
    logic             edge_seen;
    logic             lost;
    logic             int_tick;

    assign edge_seen = sync_lvl & ~prev_q;
    assign lost      = !edge_seen && (gap_q >= GAP_W'(LOSS_LIMIT - 1));
    assign int_tick  = (div_q == DIV_W'(INT_DIV - 1));

    // Remember previous level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_lvl;
    end

    // Cycles since the last edge, saturating at the loss limit
    always_ff @(posedge clk) begin
        if (!rst_n)                         gap_q <= '0;
        else if (edge_seen)                 gap_q <= '0;
        else if (gap_q != GAP_W'(LOSS_LIMIT)) gap_q <= gap_q + 1'b1;
    end

    // Loss flag and the run of good edges that clears it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_off <= 1'b1;
            run_q   <= '0;
        end else if (lost) begin
            clk_off <= 1'b1;
            run_q   <= '0;
        end else if (edge_seen && clk_off) begin
            if (run_q == RUN_W'(GOOD_EDGES - 1)) begin
                clk_off <= 1'b0;
                run_q   <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    // Free-running internal divider
    always_ff @(posedge clk) begin
        if (!rst_n)        div_q <= '0;
        else if (int_tick) div_q <= '0;
        else               div_q <= div_q + 1'b1;
    end

    // Registered strobe from the selected source
    always_ff @(posedge clk) begin
        if (!rst_n) tick <= 1'b0;
        else        tick <= clk_off ? int_tick : edge_seen;
    end
endmodule

// File: rtl/pcnt_status_bank.sv
// Module: status and control register bank for a pulse counter. Compares the
// count with a programmable value, keeps sticky input status, records count
// direction and carry, and monitors the sync clock. Assumes cnt_value,
// cnt_step, cnt_dir and carry_pulse are synchronous to clk and CNT_W is twice
// the bus width.
module pcnt_status_bank
    import pcnt_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2,
    parameter int LOSS_LIMIT  = 16,
    parameter int GOOD_EDGES  = 4,
    parameter int INT_DIV     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_value,
    input  logic              cnt_step,
    input  logic              cnt_dir,
    input  logic              carry_pulse,
    input  logic              latch_in,
    input  logic              stop_in,
    input  logic              origin_in,
    input  logic              sync_clk_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              cmp_less,
    output logic              cmp_equal,
    output logic              clk_off,
    output logic              sample_tick
);
    localparam int HALF_W = CNT_W / 2;
    localparam int N_ASYNC = 4;

    logic [CNT_W-1:0]   cmp_q;
    logic [CTL_W-1:0]   ctrl_q;
    logic               dir_q;
    logic               latch_prev_q;
    logic [N_ASYNC-1:0] async_s;
    logic               latch_s, stop_s, origin_s, sync_s;
    logic               latch_edge;
    logic               clr_wr;
    logic [SK_N-1:0]    sticky_set, sticky_clr, sticky_q;
    status_t            stat;

    // Bring the asynchronous inputs into the clock domain
    pcnt_sync #(.WIDTH(N_ASYNC), .STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sync_clk_in, origin_in, stop_in, latch_in}),
        .dout (async_s)
    );
    assign {sync_s, origin_s, stop_s, latch_s} = async_s;

    // Sync clock monitor and sample strobe source
    pcnt_clk_mon #(
        .LOSS_LIMIT(LOSS_LIMIT),
        .GOOD_EDGES(GOOD_EDGES),
        .INT_DIV   (INT_DIV)
    ) mon_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_lvl(sync_s),
        .clk_off (clk_off),
        .tick    (sample_tick)
    );

    // Previous latch level for edge selection
    always_ff @(posedge clk) begin
        if (!rst_n) latch_prev_q <= 1'b0;
        else        latch_prev_q <= latch_s;
    end

    assign latch_edge = ctrl_q[CTL_RISE_SEL] ? (latch_s & ~latch_prev_q)
                                             : (~latch_s & latch_prev_q);

    // Compare and control registers written from the bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q  <= '0;
            ctrl_q <= '0;
        end else if (bus_wr) begin
            case (reg_addr_e'(bus_addr))
                REG_CMP_LO: cmp_q[HALF_W-1:0]     <= bus_wdata[HALF_W-1:0];
                REG_CMP_HI: cmp_q[CNT_W-1:HALF_W] <= bus_wdata[HALF_W-1:0];
                REG_CTRL:   ctrl_q                <= bus_wdata[CTL_W-1:0];
                default: ;
            endcase
        end
    end

    // Direction of the most recent count step
    always_ff @(posedge clk) begin
        if (!rst_n)        dir_q <= 1'b0;
        else if (cnt_step) dir_q <= cnt_dir;
    end

    // Set conditions for each sticky slot
    always_comb begin
        sticky_set            = '0;
        sticky_set[SK_CARRY]  = carry_pulse;
        sticky_set[SK_EQ]     = (cnt_value == cmp_q);
        sticky_set[SK_LATCH]  = ctrl_q[CTL_LATCH_EN] & latch_edge;
        sticky_set[SK_STOP]   = ctrl_q[CTL_STOP_EN] & stop_s;
        sticky_set[SK_ORIGIN] = origin_s;
    end

    // Write-zero clears, one clear-register bit per slot
    assign clr_wr = bus_wr && (reg_addr_e'(bus_addr) == REG_CLR);
    for (genvar k = 0; k < SK_N; k++) begin : g_clr
        assign sticky_clr[k] = clr_wr & ~bus_wdata[clr_bit(k)];
    end

    pcnt_sticky #(.WIDTH(SK_N)) sticky_i (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (sticky_set),
        .clr  (sticky_clr),
        .q    (sticky_q)
    );

    assign cmp_less  = (cnt_value < cmp_q);
    assign cmp_equal = sticky_q[SK_EQ];

    // Assemble the status word
    always_comb begin
        stat.dir     = dir_q;
        stat.clk_off = clk_off;
        stat.origin  = sticky_q[SK_ORIGIN];
        stat.stop    = sticky_q[SK_STOP];
        stat.latch   = sticky_q[SK_LATCH];
        stat.equal   = sticky_q[SK_EQ];
        stat.less    = cmp_less;
        stat.carry   = sticky_q[SK_CARRY];
    end

    // Read multiplexer
    always_comb begin
        case (reg_addr_e'(bus_addr))
            REG_CNT_LO: bus_rdata = DATA_W'(cnt_value[HALF_W-1:0]);
            REG_CNT_HI: bus_rdata = DATA_W'(cnt_value[CNT_W-1:HALF_W]);
            REG_CMP_LO: bus_rdata = DATA_W'(cmp_q[HALF_W-1:0]);
            REG_CMP_HI: bus_rdata = DATA_W'(cmp_q[CNT_W-1:HALF_W]);
            REG_CTRL:   bus_rdata = DATA_W'(ctrl_q);
            REG_STAT:   bus_rdata = DATA_W'(stat);
            REG_CLR:    bus_rdata = CLR_READBACK;
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pcnt_status_bank_chk.sv
// Module: property checker for the pulse counter status bank, bound to it.
module pcnt_status_bank_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt_value,
    input logic [CNT_W-1:0] cmp_val,
    input logic             cmp_less,
    input logic             cmp_equal,
    input logic [2:0]       bus_addr,
    input logic             bus_wr,
    input logic [15:0]      bus_wdata,
    input logic [15:0]      bus_rdata,
    input logic             origin_flag
);
    AST_LESS_NOT_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmp_less && (cnt_value == cmp_val))); // R1

    AST_EQ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_value == cmp_val) |=> cmp_equal); // R2

    AST_EQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_equal && !(bus_wr && bus_addr == 3'd6 && !bus_wdata[12])) |=> cmp_equal); // R2

    AST_CLR_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 3'd6) |-> (bus_rdata == 16'hF001)); // R7

    AST_ORIGIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (origin_flag && !(bus_wr && bus_addr == 3'd6 && !bus_wdata[15])) |=> origin_flag); // R5

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd6 && !bus_wdata[12] && cnt_value == cmp_val) |=> cmp_equal); // R10
endmodule

bind pcnt_status_bank pcnt_status_bank_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_value  (cnt_value),
    .cmp_val    (cmp_q),
    .cmp_less   (cmp_less),
    .cmp_equal  (cmp_equal),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .origin_flag(sticky_q[4])
);

// File: tb/pcnt_status_bank_tb_top.sv
// Bench: sweeps the compare values, the latch enable/edge matrix and the
// sticky clears, and checks clock-loss timing, all against expected values
// computed here.
module pcnt_status_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cnt_value = '0;
    logic        cnt_step = 1'b0, cnt_dir = 1'b0, carry_pulse = 1'b0;
    logic        latch_in = 1'b0, stop_in = 1'b0, origin_in = 1'b0, sync_clk_in = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        cmp_less, cmp_equal, clk_off, sample_tick;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    pcnt_status_bank dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_value(cnt_value), .cnt_step(cnt_step),
        .cnt_dir(cnt_dir), .carry_pulse(carry_pulse), .latch_in(latch_in),
        .stop_in(stop_in), .origin_in(origin_in), .sync_clk_in(sync_clk_in),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cmp_less(cmp_less), .cmp_equal(cmp_equal),
        .clk_off(clk_off), .sample_tick(sample_tick)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic status_bit(input int b, output logic v);
        logic [15:0] d;
        bus_read(3'd5, d);
        v = d[b];
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sync_edges(input int n, input int half);
        repeat (n) begin
            sync_clk_in = 1'b1; wait_cyc(half);
            sync_clk_in = 1'b0; wait_cyc(half);
        end
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [15:0] d;
        logic        v;
        logic [31:0] vals [5];
        int          ticks;
        vals = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h0001_0000, 32'h0000_FFFF};

        // Reset state, read while reset is still held
        wait_cyc(4);
        bus_read(3'd5, d); check("R8 reset status (clk_off only)", d, 16'h0040);
        bus_read(3'd6, d); check("R7 reset clear readback", d, 16'hF001);
        bus_read(3'd4, d); check("R12 reset control", d, 16'h0000);
        rst_n = 1'b1;
        wait_cyc(2);

        // R12 register map
        cnt_value = 32'h1234_ABCD;
        bus_read(3'd0, d); check("R12 counter low", d, 16'hABCD);
        bus_read(3'd1, d); check("R12 counter high", d, 16'h1234);
        bus_write(3'd2, 16'h5A5A); bus_write(3'd3, 16'hC3C3);
        bus_read(3'd2, d); check("R12 compare low", d, 16'h5A5A);
        bus_read(3'd3, d); check("R12 compare high", d, 16'hC3C3);
        bus_write(3'd4, 16'hFFFF);
        bus_read(3'd4, d); check("R12 control width", d, 16'h0007);
        bus_write(3'd4, 16'h0000);
        bus_read(3'd7, d); check("R12 unused address", d, 16'h0000);

        // R1/R2/R10 compare sweep; clearing while equal leaves the flag set
        foreach (vals[i]) begin
            foreach (vals[j]) begin
                bus_write(3'd2, vals[j][15:0]);
                bus_write(3'd3, vals[j][31:16]);
                cnt_value = vals[i];
                bus_write(3'd6, 16'hEFFF);
                status_bit(1, v); check("R1 less flag", v, vals[i] < vals[j]);
                check("R1 less port", cmp_less, vals[i] < vals[j]);
                status_bit(2, v); check("R2 R10 equal after clear", v, vals[i] == vals[j]);
            end
        end
        // R2 holds after the values part, then clears
        bus_write(3'd2, 16'h0005); bus_write(3'd3, 16'h0000);
        cnt_value = 32'h5; wait_cyc(1);
        cnt_value = 32'h6; wait_cyc(3);
        check("R2 equal holds", cmp_equal, 1'b1);
        bus_write(3'd6, 16'hEFFF);
        check("R2 equal cleared", cmp_equal, 1'b0);

        // R3 latch matrix: enable x edge select x input edge
        for (int en = 0; en < 2; en++) begin
            for (int sel = 0; sel < 2; sel++) begin
                for (int rise = 0; rise < 2; rise++) begin
                    bus_write(3'd4, 16'((sel << 2) | en));
                    latch_in = (rise == 0); wait_cyc(5);
                    bus_write(3'd6, 16'hDFFF);
                    latch_in = (rise == 1); wait_cyc(5);
                    status_bit(3, v);
                    check("R3 latch edge capture", v, (en == 1) && (sel == rise));
                end
            end
        end
        bus_write(3'd6, 16'hDFFF);
        status_bit(3, v); check("R3 latch clear", v, 1'b0);

        // R4 stop with and without enable; holds after input falls
        for (int en = 0; en < 2; en++) begin
            bus_write(3'd4, 16'(en << 1));
            stop_in = 1'b0; wait_cyc(5);
            bus_write(3'd6, 16'hBFFF);
            stop_in = 1'b1; wait_cyc(5);
            stop_in = 1'b0; wait_cyc(5);
            status_bit(4, v); check("R4 stop sticky", v, en == 1);
        end
        bus_write(3'd6, 16'hBFFF);
        status_bit(4, v); check("R4 stop clear", v, 1'b0);

        // R11 synchroniser latency on origin, R5 hold and R10 priority
        bus_write(3'd6, 16'h7FFF);
        origin_in = 1'b1;
        wait_cyc(2); status_bit(5, v); check("R11 origin not before third edge", v, 1'b0);
        wait_cyc(1); status_bit(5, v); check("R11 origin at third edge", v, 1'b1);
        bus_write(3'd6, 16'h7FFF);
        status_bit(5, v); check("R10 origin set beats clear", v, 1'b1);
        origin_in = 1'b0; wait_cyc(5);
        status_bit(5, v); check("R5 origin holds", v, 1'b1);
        bus_write(3'd6, 16'hFFFF);
        status_bit(5, v); check("R5 clear with bit15 one ignored", v, 1'b1);
        bus_write(3'd6, 16'h7FFF);
        status_bit(5, v); check("R5 origin clear", v, 1'b0);

        // R6 direction
        @(negedge clk); cnt_step = 1'b1; cnt_dir = 1'b1;
        @(negedge clk); cnt_step = 1'b0; cnt_dir = 1'b0;
        status_bit(7, v); check("R6 reverse step", v, 1'b1);
        wait_cyc(2); status_bit(7, v); check("R6 no step no change", v, 1'b1);
        @(negedge clk); cnt_step = 1'b1;
        @(negedge clk); cnt_step = 1'b0;
        status_bit(7, v); check("R6 forward step", v, 1'b0);

        // R7 carry
        @(negedge clk); carry_pulse = 1'b1;
        @(negedge clk); carry_pulse = 1'b0;
        status_bit(0, v); check("R7 carry set", v, 1'b1);
        bus_write(3'd6, 16'hFFFE);
        status_bit(0, v); check("R7 carry clear", v, 1'b0);
        bus_read(3'd6, d); check("R7 clear readback after write", d, 16'hF001);

        // R8/R9 clock monitor: still lost here, internal ticks every 8 cycles
        check("R8 lost with idle sync", clk_off, 1'b1);
        ticks = 0;
        repeat (64) begin @(negedge clk); if (sample_tick) ticks++; end
        check("R9 internal tick count", ticks, 8);
        sync_edges(3, 4);
        check("R8 three edges not enough", clk_off, 1'b1);
        sync_edges(1, 4);
        wait_cyc(2);
        check("R8 recovered after four edges", clk_off, 1'b0);
        ticks = 0;
        fork
            sync_edges(5, 4);
            repeat (46) begin @(negedge clk); if (sample_tick) ticks++; end
        join
        check("R9 ticks follow sync edges", ticks, 5);
        wait_cyc(2);
        check("R8 short gap keeps clock", clk_off, 1'b0);
        wait_cyc(8);
        check("R8 loss after 16 idle cycles", clk_off, 1'b1);

        finish_run();
    end
endmodule